// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This unit adds or subtracts two 32-bit single-precision binary floating-point words. It takes a destination operand, a source operand and an operation select. When the select is high, the sign of the source is inverted and the unit then adds. The result word and three status flags are registered. They appear one clock after the operands are presented. A new operation can start on every cycle.

Special values are resolved by a fixed priority. A NaN in the destination wins over everything. A NaN in the source comes next. Infinities come after that. Only when both operands are finite does the arithmetic path run.

The arithmetic path has these properties:
- Input subnormals are read as signed zeros.
- Sums are rounded to nearest, with ties going to even.
- Results beyond the largest finite value saturate to infinity.
- Results below the smallest normal value flush to zero.
- A sum that is exactly zero has its sign fixed by one rule.

The unit is meant for a datapath that needs single-cycle add throughput and can live without subnormal outputs and without rounding-mode control.

Top module: `spa_addsub`

## Requirements
- R1: Each operation is registered once. The result and flags reflect the operands that were sampled at the previous rising clock edge. While reset is asserted, the result is 0x00000000, neg_o is 0, zero_o is 1 and nan_o is 0.
- R2: If the destination is a NaN (exponent field bits 30:23 all ones and fraction bits 22:0 nonzero), the result is the destination word bit for bit. This holds whatever the source and the select are.
- R3: If the source is a NaN and the destination is not, the result is the original source word bit for bit. This holds even on a subtract.
- R4: If exactly one operand is an infinity (exponent all ones, fraction zero) and the other is finite, the result is that infinity with its effective sign.
- R5: If both operands are infinities with different effective signs, the result is 0x7FC00000. With equal effective signs, the result is that infinity.
- R6: When both operands are finite, the sum is rounded to 24 significant bits, to nearest, with ties going to the even significand.
- R7: A finite sum whose rounded magnitude reaches exponent 255 returns infinity of the sum's sign (0x7F800000 or 0xFF800000).
- R8: A nonzero finite sum whose normalised biased exponent is below 1 returns zero carrying the sum's sign.
- R9: A finite sum that is exactly zero returns 0x80000000 only when both effective operands are negative. Otherwise it returns 0x00000000.
- R10: An input with exponent field 0 and a nonzero fraction is treated as zero with the sign of that input.
- R11: With sub_i high, the result equals the add result with bit 31 of the source inverted. The one exception is the NaN passthrough of R3.
- R12: neg_o equals result bit 31. zero_o is 1 exactly when result bits 30:0 are all zero. nan_o is 1 exactly when the result exponent is all ones and its fraction is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dst_i | input | 32 | Destination operand (minuend or first addend) |
| src_i | input | 32 | Source operand (subtrahend or second addend) |
| sub_i | input | 1 | 1 selects subtract, 0 selects add |
| result_o | output | 32 | Registered result word |
| neg_o | output | 1 | Sign bit of the result |
| zero_o | output | 1 | Result is a zero of either sign |
| nan_o | output | 1 | Result is a NaN |

## Verification
Directed operand pairs separate each branch of the special-value priority:
- a NaN on both sides shows that the destination wins;
- a NaN in the source on a subtract shows that its sign bit is left untouched;
- infinities are paired against finite values and against each other in both sign combinations.

Finite pairs test the rounding. Exact half-ulp ties with odd and even significands tell round-to-even apart from round-half-up. Near-cancelling pairs at the smallest exponent test the flush to zero. Pairs at the largest exponent test saturation. Signed-zero and subnormal pairs test the zero sign rule.

A long stream of random pairs follows. It mixes close exponents, extreme exponents and special values, and is compared on every clock against a reference model in the bench. The model uses exact wide-integer arithmetic instead of guard bits.

// File: rtl/spa_pkg.sv
package spa_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;          // significand with hidden bit
    localparam int XTRA   = 3;                   // guard, round, sticky
    localparam int EXT_W  = SIG_W + XTRA;        // aligned significand width
    localparam int SUM_W  = EXT_W + 1;           // room for carry-out
    localparam int EXPV_W = EXP_W + 2;           // signed working exponent

    localparam logic [EXP_W-1:0]  EXP_ONES  = {EXP_W{1'b1}};
    localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
        logic              zero;
        logic              inf;
        logic              nan;
    } opnd_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              neg;
        logic              zero;
        logic              nan;
        logic              started;
    } state_t;

    localparam state_t STATE_RST = '{word: '0, neg: 1'b0, zero: 1'b1, nan: 1'b0, started: 1'b0};

endpackage

// File: rtl/spa_unpack.sv
module spa_unpack
    import spa_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              flip_i,
    output opnd_t             op_o
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f       = word_i[WORD_W-2 -: EXP_W];
        frac_f      = word_i[FRAC_W-1:0];
        op_o.sign   = word_i[WORD_W-1] ^ flip_i;
        op_o.exp    = exp_f;
        // exponent zero: true zero or subnormal, both read as signed zero
        op_o.zero   = (exp_f == '0);
        op_o.inf    = (exp_f == EXP_ONES) && (frac_f == '0);
        op_o.nan    = (exp_f == EXP_ONES) && (frac_f != '0);
        op_o.sig    = (exp_f == '0) ? '0 : {1'b1, frac_f};
    end

endmodule

// File: rtl/spa_align.sv
module spa_align
    import spa_pkg::*;
(
    input  logic              a_sign_i,
    input  logic [EXP_W-1:0]  a_exp_i,
    input  logic [SIG_W-1:0]  a_sig_i,
    input  logic              b_sign_i,
    input  logic [EXP_W-1:0]  b_exp_i,
    input  logic [SIG_W-1:0]  b_sig_i,
    output logic              sign_o,
    output logic [EXPV_W-1:0] exp_o,
    output logic [SUM_W-1:0]  sum_o
);

    localparam logic [EXP_W-1:0] DIFF_CAP = EXP_W'(EXT_W);

    logic             a_ge;
    logic             big_sign, sml_sign;
    logic [EXP_W-1:0] big_exp, sml_exp, diff;
    logic [SIG_W-1:0] big_sig, sml_sig;
    logic [EXT_W-1:0] sml_ext, sml_sh, sml_al, big_ext;
    logic             lost;

    always_comb begin
        a_ge     = {a_exp_i, a_sig_i} >= {b_exp_i, b_sig_i};
        big_sign = a_ge ? a_sign_i : b_sign_i;
        big_exp  = a_ge ? a_exp_i  : b_exp_i;
        big_sig  = a_ge ? a_sig_i  : b_sig_i;
        sml_sign = a_ge ? b_sign_i : a_sign_i;
        sml_exp  = a_ge ? b_exp_i  : a_exp_i;
        sml_sig  = a_ge ? b_sig_i  : a_sig_i;

        diff    = big_exp - sml_exp;
        big_ext = {big_sig, {XTRA{1'b0}}};
        sml_ext = {sml_sig, {XTRA{1'b0}}};
        sml_sh  = '0;
        lost    = 1'b0;
        sml_al  = '0;
        if (diff >= DIFF_CAP) begin
            // entirely below the round position: only stickiness survives
            sml_al[0] = |sml_sig;
        end else begin
            sml_sh = sml_ext >> diff;
            lost   = (sml_sh << diff) != sml_ext;
            sml_al = {sml_sh[EXT_W-1:1], sml_sh[0] | lost};
        end

        if (big_sign == sml_sign)
            sum_o = {1'b0, big_ext} + {1'b0, sml_al};
        else
            sum_o = {1'b0, big_ext} - {1'b0, sml_al};

        sign_o = big_sign;
        exp_o  = {2'b00, big_exp};
    end

endmodule

// File: rtl/spa_round.sv
module spa_round
    import spa_pkg::*;
(
    input  logic              sign_i,
    input  logic [EXPV_W-1:0] exp_i,
    input  logic [SUM_W-1:0]  sum_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int RS_W = SIG_W + 1;
    localparam logic signed [EXPV_W-1:0] E_MIN = EXPV_W'(1);
    localparam logic signed [EXPV_W-1:0] E_INF = EXPV_W'((1 << EXP_W) - 1);

    logic [EXPV_W-1:0] lz;
    logic [EXT_W-1:0]  m;
    logic [EXPV_W-1:0] e_norm, e_fin;
    logic              g, rest, up;
    logic [RS_W-1:0]   rs;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        lz = '0;
        for (int i = 0; i < EXT_W; i++) begin
            if (sum_i[i]) lz = EXPV_W'(EXT_W - 1 - i);
        end

        if (sum_i[SUM_W-1]) begin
            m      = {sum_i[SUM_W-1:2], |sum_i[1:0]};
            e_norm = exp_i + EXPV_W'(1);
        end else begin
            m      = sum_i[EXT_W-1:0] << lz;
            e_norm = exp_i - lz;
        end

        g    = m[XTRA-1];
        rest = |m[XTRA-2:0];
        up   = g & (rest | m[XTRA]);
        rs   = {1'b0, m[EXT_W-1:XTRA]} + RS_W'(up);

        e_fin = rs[RS_W-1] ? e_norm + EXPV_W'(1) : e_norm;
        frac  = rs[RS_W-1] ? '0 : rs[FRAC_W-1:0];

        if ($signed(e_norm) < E_MIN)
            word_o = {sign_i, {(WORD_W-1){1'b0}}};
        else if ($signed(e_fin) >= E_INF)
            word_o = {sign_i, EXP_ONES, {FRAC_W{1'b0}}};
        else
            word_o = {sign_i, e_fin[EXP_W-1:0], frac};
    end

endmodule

// File: rtl/spa_addsub.sv
module spa_addsub
    import spa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] dst_i,
    input  logic [WORD_W-1:0] src_i,
    input  logic              sub_i,
    output logic [WORD_W-1:0] result_o,
    output logic              neg_o,
    output logic              zero_o,
    output logic              nan_o
);

    opnd_t             op_a, op_b;
    logic              al_sign;
    logic [EXPV_W-1:0] al_exp;
    logic [SUM_W-1:0]  al_sum;
    logic [WORD_W-1:0] rnd_word;
    logic [WORD_W-1:0] w;
    state_t            st_d, st_q;

    spa_unpack u_unpack_dst (.word_i(dst_i), .flip_i(1'b0),  .op_o(op_a));
    spa_unpack u_unpack_src (.word_i(src_i), .flip_i(sub_i), .op_o(op_b));

    spa_align u_align (
        .a_sign_i (op_a.sign), .a_exp_i (op_a.exp), .a_sig_i (op_a.sig),
        .b_sign_i (op_b.sign), .b_exp_i (op_b.exp), .b_sig_i (op_b.sig),
        .sign_o   (al_sign),   .exp_o   (al_exp),   .sum_o   (al_sum)
    );

    spa_round u_round (.sign_i(al_sign), .exp_i(al_exp), .sum_i(al_sum), .word_o(rnd_word));

    always_comb begin
        st_d = st_q;
        st_d.started = 1'b1;
        if (op_a.nan)
            w = dst_i;
        else if (op_b.nan)
            w = src_i;
        else if (op_a.inf && op_b.inf)
            w = (op_a.sign == op_b.sign) ? dst_i : QNAN_WORD;
        else if (op_a.inf)
            w = dst_i;
        else if (op_b.inf)
            w = {op_b.sign, src_i[WORD_W-2:0]};
        else if ((op_a.zero && op_b.zero) || (al_sum == '0))
            w = {op_a.sign & op_b.sign, {(WORD_W-1){1'b0}}};
        else
            w = rnd_word;
        st_d.word = w;
        st_d.neg  = w[WORD_W-1];
        st_d.zero = (w[WORD_W-2:0] == '0);
        st_d.nan  = (w[WORD_W-2 -: EXP_W] == EXP_ONES) && (w[FRAC_W-1:0] != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STATE_RST;
        else        st_q <= st_d;
    end

    assign result_o = st_q.word;
    assign neg_o    = st_q.neg;
    assign zero_o   = st_q.zero;
    assign nan_o    = st_q.nan;

    assert_dst_nan_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && $past(op_a.nan)) |-> (result_o == $past(dst_i)))
        else $error("R2: destination NaN not returned unchanged");

    assert_src_nan_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && $past(op_b.nan && !op_a.nan)) |-> (result_o == $past(src_i)))
        else $error("R3: source NaN not returned unchanged");

    assert_lone_src_inf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && $past(op_b.inf && !op_a.inf && !op_a.nan)) |->
        (result_o == {$past(src_i[WORD_W-1] ^ sub_i), EXP_ONES, {FRAC_W{1'b0}}}))
        else $error("R4: lone source infinity not returned");

    assert_opposite_inf_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && $past(op_a.inf && op_b.inf && (op_a.sign != op_b.sign))) |->
        (result_o == QNAN_WORD))
        else $error("R5: opposite infinities did not yield generated NaN");

    assert_zero_pair_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && $past(op_a.zero && op_b.zero)) |->
        (result_o == {$past(op_a.sign & op_b.sign), {(WORD_W-1){1'b0}}}))
        else $error("R9: zero pair sign rule broken");

endmodule

// File: tb/tb_spa_addsub.sv
module tb_spa_addsub;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dst_i = 32'h1234_5678;
    logic [31:0] src_i = 32'h9ABC_DEF0;
    logic        sub_i = 1'b1;
    logic [31:0] result_o;
    logic        neg_o, zero_o, nan_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spa_addsub dut (
        .clk(clk), .rst_n(rst_n), .dst_i(dst_i), .src_i(src_i), .sub_i(sub_i),
        .result_o(result_o), .neg_o(neg_o), .zero_o(zero_o), .nan_o(nan_o)
    );

    // Behavioural reference: exact wide-integer sum, then rounding.
    function automatic logic [31:0] ref_add(input logic [31:0] d, input logic [31:0] s, input logic sub);
        logic [31:0] b, big, sml;
        int ea, eb, e_big, e_sml, diff, p, e, sh;
        logic [64:0] A, B, S, keep, rem, half;
        logic sign;
        b  = s ^ (sub ? 32'h8000_0000 : 32'h0);
        ea = int'(d[30:23]);
        eb = int'(b[30:23]);
        if (ea == 255 && d[22:0] != 0) return d;
        if (eb == 255 && b[22:0] != 0) return s;
        if (ea == 255 && eb == 255) return (d[31] == b[31]) ? d : 32'h7FC0_0000;
        if (ea == 255) return d;
        if (eb == 255) return b;
        if (ea == 0 && eb == 0) return {d[31] & b[31], 31'b0};
        if (ea == 0) return b;
        if (eb == 0) return d;
        if (d[30:0] >= b[30:0]) begin big = d; sml = b; end
        else begin big = b; sml = d; end
        e_big = int'(big[30:23]);
        e_sml = int'(sml[30:23]);
        diff  = e_big - e_sml;
        sign  = big[31];
        if (diff > 40) return big;
        A = 65'({1'b1, big[22:0]}) << diff;
        B = 65'({1'b1, sml[22:0]});
        S = (big[31] == sml[31]) ? A + B : A - B;
        if (S == 0) return 32'h0;
        p = 0;
        for (int i = 0; i < 65; i++) if (S[i]) p = i;
        e = e_sml + p - 23;
        if (e < 1) return {sign, 31'b0};
        if (p > 23) begin
            sh   = p - 23;
            keep = S >> sh;
            rem  = S & ((65'd1 << sh) - 65'd1);
            half = 65'd1 << (sh - 1);
            if (rem > half || (rem == half && keep[0])) keep = keep + 65'd1;
        end else begin
            keep = S << (23 - p);
        end
        if (keep[24]) begin keep = keep >> 1; e = e + 1; end
        if (e >= 255) return {sign, 8'hFF, 23'b0};
        return {sign, 8'(e), keep[22:0]};
    endfunction

    task automatic compare(input logic [31:0] want, input string tag);
        logic wn, wz, wv;
        wn = want[31];
        wz = (want[30:0] == 0);
        wv = (want[30:23] == 8'hFF) && (want[22:0] != 0);
        checks++;
        if (result_o !== want || neg_o !== wn || zero_o !== wz || nan_o !== wv) begin
            errors++;
            $display("FAIL %s: got %h n%b z%b v%b expected %h n%b z%b v%b",
                     tag, result_o, neg_o, zero_o, nan_o, want, wn, wz, wv);
        end
    endtask

    task automatic check_head();
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    endtask

    task automatic step(input logic [31:0] d, input logic [31:0] s, input logic sb, input string tag);
        @(negedge clk);
        check_head();
        dst_i = d;
        src_i = s;
        sub_i = sb;
        exp_q.push_back(ref_add(d, s, sb));
        tag_q.push_back(tag);
    endtask

    function automatic logic [31:0] pick(input int base);
        int k, ex;
        logic [22:0] f;
        logic sg;
        k  = int'($urandom_range(0, 15));
        f  = 23'($urandom);
        sg = 1'($urandom);
        case (k)
            0: return {sg, 8'hFF, f | 23'd1};
            1: return {sg, 8'hFF, 23'd0};
            2: return {sg, 8'h00, ($urandom_range(0, 1) == 1) ? f : 23'd0};
            3: return {sg, 8'(254 - int'($urandom_range(0, 2))), f};
            4: return {sg, 8'(1 + int'($urandom_range(0, 2))), f};
            5: return {sg, 8'($urandom_range(1, 254)), f};
            default: begin
                ex = base + int'($urandom_range(0, 60)) - 30;
                if (ex < 1) ex = 1;
                if (ex > 254) ex = 254;
                return {sg, 8'(ex), f};
            end
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(32'h0000_0000, "R1 reset state");
        rst_n = 1'b1;

        // R2: destination NaN wins, also over a source NaN
        step(32'h7FC0_0001, 32'h3F80_0000, 1'b0, "R2 dst nan");
        step(32'hFF80_0055, 32'h7FC0_0000, 1'b1, "R2 dst nan over src nan");
        // R3: source NaN unchanged even on subtract
        step(32'h3F80_0000, 32'hFF80_0123, 1'b1, "R3 src nan sub");
        step(32'h7F80_0000, 32'h7FFF_FFFF, 1'b0, "R3 src nan vs inf");
        // R4: lone infinity
        step(32'h7F80_0000, 32'h3F80_0000, 1'b0, "R4 dst inf");
        step(32'h3F80_0000, 32'h7F80_0000, 1'b1, "R4 src inf negated");
        step(32'hC2C8_0000, 32'hFF80_0000, 1'b0, "R4 src minus inf");
        // R5: infinity pairs
        step(32'h7F80_0000, 32'hFF80_0000, 1'b0, "R5 opposite inf");
        step(32'h7F80_0000, 32'h7F80_0000, 1'b1, "R5 inf minus inf");
        step(32'hFF80_0000, 32'hFF80_0000, 1'b0, "R5 same minus inf");
        // R6: rounding ties and non-ties
        step(32'h3F80_0000, 32'h3380_0000, 1'b0, "R6 tie to even down");
        step(32'h3F80_0001, 32'h3380_0000, 1'b0, "R6 tie to even up");
        step(32'h3F80_0000, 32'h3440_0000, 1'b0, "R6 above half");
        step(32'h3F80_0000, 32'h3F80_0000, 1'b0, "R6 one plus one");
        step(32'h3FC0_0000, 32'h4010_0000, 1'b0, "R6 mixed");
        // R7: overflow saturates
        step(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, "R7 overflow positive");
        step(32'hFF7F_FFFF, 32'h7F7F_FFFF, 1'b1, "R7 overflow negative");
        // R8: underflow flushes
        step(32'h0080_0001, 32'h0080_0000, 1'b1, "R8 flush positive");
        step(32'h8080_0001, 32'h8080_0000, 1'b1, "R8 flush negative");
        // R9: exact zero sign rule
        step(32'h3F80_0000, 32'h3F80_0000, 1'b1, "R9 cancel");
        step(32'h8000_0000, 32'h8000_0000, 1'b0, "R9 both minus zero");
        step(32'h8000_0000, 32'h0000_0000, 1'b1, "R9 minus zero sub plus zero");
        step(32'h0000_0000, 32'h8000_0000, 1'b0, "R9 mixed zeros");
        step(32'hBF80_0000, 32'h3F80_0000, 1'b0, "R9 opposite cancel");
        // R10: subnormal inputs as zero
        step(32'h0000_0005, 32'h3F80_0000, 1'b0, "R10 subnormal dst");
        step(32'h8000_0001, 32'h8000_0002, 1'b0, "R10 subnormal pair");
        // R11: subtraction
        step(32'h4040_0000, 32'h3F80_0000, 1'b1, "R11 three minus one");
        step(32'h3F80_0000, 32'hC000_0000, 1'b1, "R11 minus negative");

        for (int n = 0; n < 4000; n++) begin
            int base;
            base = int'($urandom_range(1, 254));
            step(pick(base), pick(base), 1'($urandom), "R12 random stream");
        end
        @(negedge clk);
        check_head();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule